// File: doc/BRIEF.md
# Cross-Domain Timer Register Bridge

This block couples a system-clock register port to an 8-bit up-counting timer that can run from a slow crystal clock instead of the system clock. When the timer runs from the system clock, host writes to the timer's count, compare and control registers take effect directly. When it runs from the crystal clock, each write lands in a holding register on the host side. A toggle handshake then carries the write into the timer domain. While the transfer is in flight, a busy flag for that register can be read on the port.

Software polls a busy flag before rewriting the matching register. A write issued while the flag is set is dropped and noted in a sticky error bit. Reads of the count return the running timer value. Reads of compare and control return the host-side holding copy. The timer raises a compare-match flag, which also drives the interrupt output. A prescaler-reset request is cleared by hardware only once it has taken effect in the timer domain, and a hold bit keeps the prescaler in reset for as long as the hold bit is set.

Top module: `async_timer_bridge`

## Requirements
- R1: After reset every register reads 0 (addresses 0 to 3) and `irq` is low.
- R2: Bit 0 of the global register (address 0) selects the timer clock: 0 runs the timer from `clk_sys`, 1 from `clk_xtal`; with the crystal source chosen and `clk_xtal` stopped, the count does not move.
- R3: In crystal mode a write to the count register (address 1) sets global bit 5. The bit stays 1 for at least two `clk_xtal` rising edges after the write and returns to 0 once the transfer is done.
- R4: Each register has its own busy flag: count sets only bit 5, compare (address 2) only bit 6, control (address 3) only bit 7.
- R5: In system-clock mode a register write reaches the timer without raising any busy flag, and the new count is readable on the next read.
- R6: A read of address 1 returns the live timer count. Reads of addresses 2 and 3 return the holding copy, which shows a new value at once, even while its busy flag is set.
- R7: Once a busy flag has cleared, the timer uses the transferred value; a stopped timer reads back the written count.
- R8: A write to a register whose busy flag is set is dropped and sets the sticky error bit 3 of the global register. Writing 1 to bit 3 clears it.
- R9: When the count equals the compare value on a count step, global bit 4 and `irq` become 1. They fall only when 1 is written to bit 4.
- R10: Writing 1 to global bit 1 requests a prescaler reset. In system-clock mode the bit reads 0 again on the next cycle. In crystal mode it stays 1 until the timer domain has acknowledged the reset.
- R11: While global bit 2 is 1, bit 1 is not cleared, the prescaler stays in reset and the count does not advance. Clearing bit 2 releases both.
- R12: A write that changes global bit 0 clears all three holding registers and all busy flags.
- R13: Control bits [2:0] set the step rate: 0 stops the count, and a value s from 1 to 7 advances it once every 2^(s-1) timer clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock for the register port |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| clk_xtal | input | 1 | Slow crystal clock, used when global bit 0 is 1 |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address: 0 global, 1 count, 2 compare, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Compare-match interrupt, equal to global bit 4 |

## Verification
The bench counts `clk_xtal` edges after a crystal-mode write and reads the busy flag during that window. A design that cleared busy after a single synchronizer stage, or set the wrong flag, fails there. It writes a second value while a transfer is still in flight and expects the first value to survive. A design without the guard would let the second value corrupt the transfer or lose the error bit. It stops the crystal clock to prove which clock drives the count. It freezes the count with the hold bit and expects the reset request to persist until the hold is released. It also switches clock source in the middle of a transfer and expects the holding registers and flags to be empty afterwards.

// File: rtl/atb_pkg.sv
`timescale 1ns/1ps
package atb_pkg;
   typedef enum logic [1:0] {
      REG_GLB = 2'd0,
      REG_CNT = 2'd1,
      REG_CMP = 2'd2,
      REG_CTL = 2'd3
   } reg_sel_e;

   // global register bit positions
   localparam int G_XSEL  = 0;
   localparam int G_PRST  = 1;
   localparam int G_HOLD  = 2;
   localparam int G_ERR   = 3;
   localparam int G_MATCH = 4;
   localparam int G_BUSY0 = 5;

   // transfer channel indices, channel i sits at address i+1
   localparam int CH_CNT = 0;
   localparam int CH_CMP = 1;
   localparam int CH_CTL = 2;
   localparam int NUM_CH = 3;
endpackage

// File: rtl/atb_sync2.sv
`timescale 1ns/1ps
module atb_sync2 #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1;
   logic [W-1:0] stage2;

   if (W < 1) begin : g_bad_w
      $error("atb_sync2: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         stage2 <= '0;
      end else begin
         stage1 <= d;
         stage2 <= stage1;
      end
   end

   assign q = stage2;
endmodule

// File: rtl/atb_xfer_chan.sv
`timescale 1ns/1ps
module atb_xfer_chan #(
   parameter int W = 8
) (
   input  logic         clk_h,
   input  logic         clk_t,
   input  logic         rst_n,
   input  logic         async_en,
   input  logic         flush,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] hold,
   output logic         busy,
   output logic         wr_err,
   output logic         ld_t
);
   logic req_h;
   logic req_t;
   logic ack_t;
   logic ack_h;

   // host -> timer request toggle
   atb_sync2 #(.W(1)) u_req_sync (
      .clk   (clk_t),
      .rst_n (rst_n),
      .d     (req_h),
      .q     (req_t)
   );

   always_ff @(posedge clk_t or negedge rst_n) begin
      if (!rst_n) ack_t <= 1'b0;
      else        ack_t <= req_t;
   end

   // one timer-clock pulse per toggle seen
   assign ld_t = req_t ^ ack_t;

   // timer -> host acknowledge toggle
   atb_sync2 #(.W(1)) u_ack_sync (
      .clk   (clk_h),
      .rst_n (rst_n),
      .d     (ack_t),
      .q     (ack_h)
   );

   always_ff @(posedge clk_h or negedge rst_n) begin
      if (!rst_n) begin
         hold  <= '0;
         busy  <= 1'b0;
         req_h <= 1'b0;
      end else if (flush) begin
         hold <= '0;
         busy <= 1'b0;
      end else if (wr && !busy) begin
         hold <= wdata;
         if (async_en) begin
            req_h <= ~req_h;
            busy  <= 1'b1;
         end
      end else if (busy && (ack_h == req_h)) begin
         busy <= 1'b0;
      end
   end

   assign wr_err = wr & busy & ~flush;
endmodule

// File: rtl/atb_core.sv
`timescale 1ns/1ps
module atb_core #(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3,
   parameter int PRE_W = 6
) (
   input  logic             clk_t,
   input  logic             rst_n,
   input  logic             ld_cnt,
   input  logic             ld_cmp,
   input  logic             ld_sel,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [SEL_W-1:0] sel_val,
   input  logic             pre_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             match_tgl
);
   localparam int SEL_MAX = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] pre_mask;
   logic [CNT_W-1:0] cmp_q;
   logic [SEL_W-1:0] sel_q;
   logic             tick;

   if (PRE_W < SEL_MAX - 1) begin : g_bad_pre
      $error("atb_core: PRE_W too small for the largest divide select");
   end

   // mask has sel-1 low ones; a step happens when they are all set
   always_comb begin
      pre_mask = '0;
      for (int i = 0; i < PRE_W; i++) begin
         if (i + 1 < int'(sel_q)) pre_mask[i] = 1'b1;
      end
   end

   assign tick = (sel_q != '0) && !pre_clr && ((pre_q & pre_mask) == pre_mask);

   always_ff @(posedge clk_t or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (pre_clr) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   always_ff @(posedge clk_t or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         sel_q <= '0;
      end else begin
         if (ld_cmp) cmp_q <= cmp_val;
         if (ld_sel) sel_q <= sel_val;
      end
   end

   always_ff @(posedge clk_t or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         match_tgl <= 1'b0;
      end else if (ld_cnt) begin
         cnt <= cnt_val;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
         if (cnt == cmp_q) match_tgl <= ~match_tgl;
      end
   end
endmodule

// File: rtl/async_timer_bridge.sv
`timescale 1ns/1ps
module async_timer_bridge #(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3,
   parameter int PRE_W = 6
) (
   input  logic             clk_sys,
   input  logic             rst_n,
   input  logic             clk_xtal,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             irq
);
   import atb_pkg::*;

   localparam int GLB_BITS = G_BUSY0 + NUM_CH;

   if (CNT_W < GLB_BITS) begin : g_bad_cnt
      $error("async_timer_bridge: CNT_W must hold the global register");
   end
   if (SEL_W < 1 || SEL_W > CNT_W) begin : g_bad_sel
      $error("async_timer_bridge: SEL_W out of range");
   end

   logic                        xsel_q, prst_q, shold_q, err_q, mflag_q;
   logic                        tclk;
   logic                        wr_glb, flush;
   logic [NUM_CH-1:0]           wr_ch, busy, ch_err, ch_ld;
   logic [NUM_CH-1:0][CNT_W-1:0] hold;
   logic [NUM_CH-1:0]           ld_core;
   logic [CNT_W-1:0]            cnt_ld_val, cmp_ld_val;
   logic [SEL_W-1:0]            sel_ld_val;
   logic [CNT_W-1:0]            cnt_t, cnt_s;
   logic                        match_tgl, match_s, match_d;
   logic                        pr_t, pr_ack, pre_clr;

   // timer clock source
   assign tclk = xsel_q ? clk_xtal : clk_sys;

   assign wr_glb = bus_wr && (bus_addr == REG_GLB);
   assign flush  = wr_glb && (bus_wdata[G_XSEL] != xsel_q);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign wr_ch[i] = bus_wr && (bus_addr == 2'(i + 1));

      atb_xfer_chan #(.W(CNT_W)) u_chan (
         .clk_h    (clk_sys),
         .clk_t    (tclk),
         .rst_n    (rst_n),
         .async_en (xsel_q),
         .flush    (flush),
         .wr       (wr_ch[i]),
         .wdata    (bus_wdata),
         .hold     (hold[i]),
         .busy     (busy[i]),
         .wr_err   (ch_err[i]),
         .ld_t     (ch_ld[i])
      );

      // direct load when the timer shares the system clock
      assign ld_core[i] = xsel_q ? ch_ld[i] : wr_ch[i];
   end

   assign cnt_ld_val = xsel_q ? hold[CH_CNT] : bus_wdata;
   assign cmp_ld_val = xsel_q ? hold[CH_CMP] : bus_wdata;
   assign sel_ld_val = xsel_q ? hold[CH_CTL][SEL_W-1:0] : bus_wdata[SEL_W-1:0];

   // prescaler reset request: level crosses over and back
   atb_sync2 #(.W(1)) u_pr_fwd (
      .clk   (tclk),
      .rst_n (rst_n),
      .d     (prst_q),
      .q     (pr_t)
   );
   atb_sync2 #(.W(1)) u_pr_back (
      .clk   (clk_sys),
      .rst_n (rst_n),
      .d     (pr_t),
      .q     (pr_ack)
   );
   assign pre_clr = xsel_q ? pr_t : prst_q;

   atb_core #(.CNT_W(CNT_W), .SEL_W(SEL_W), .PRE_W(PRE_W)) u_core (
      .clk_t     (tclk),
      .rst_n     (rst_n),
      .ld_cnt    (ld_core[CH_CNT]),
      .ld_cmp    (ld_core[CH_CMP]),
      .ld_sel    (ld_core[CH_CTL]),
      .cnt_val   (cnt_ld_val),
      .cmp_val   (cmp_ld_val),
      .sel_val   (sel_ld_val),
      .pre_clr   (pre_clr),
      .cnt       (cnt_t),
      .match_tgl (match_tgl)
   );

   atb_sync2 #(.W(CNT_W)) u_cnt_sync (
      .clk   (clk_sys),
      .rst_n (rst_n),
      .d     (cnt_t),
      .q     (cnt_s)
   );
   atb_sync2 #(.W(1)) u_match_sync (
      .clk   (clk_sys),
      .rst_n (rst_n),
      .d     (match_tgl),
      .q     (match_s)
   );

   // global register
   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         xsel_q  <= 1'b0;
         shold_q <= 1'b0;
         prst_q  <= 1'b0;
         err_q   <= 1'b0;
         mflag_q <= 1'b0;
         match_d <= 1'b0;
      end else begin
         match_d <= match_s;
         if (wr_glb) begin
            xsel_q  <= bus_wdata[G_XSEL];
            shold_q <= bus_wdata[G_HOLD];
         end
         if (wr_glb && bus_wdata[G_PRST])
            prst_q <= 1'b1;
         else if (prst_q && !shold_q && (!xsel_q || pr_ack))
            prst_q <= 1'b0;
         if (|ch_err)
            err_q <= 1'b1;
         else if (wr_glb && bus_wdata[G_ERR])
            err_q <= 1'b0;
         if (match_s ^ match_d)
            mflag_q <= 1'b1;
         else if (wr_glb && bus_wdata[G_MATCH])
            mflag_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (bus_addr)
         REG_GLB: bus_rdata = CNT_W'({busy, mflag_q, err_q, shold_q, prst_q, xsel_q});
         REG_CNT: bus_rdata = xsel_q ? cnt_s : cnt_t;
         REG_CMP: bus_rdata = hold[CH_CMP];
         default: bus_rdata = hold[CH_CTL];
      endcase
   end

   assign irq = mflag_q;
endmodule

// File: rtl/atb_checker.sv
`timescale 1ns/1ps
module atb_checker #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [1:0]    bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic          xsel,
   input logic          prst,
   input logic          shold,
   input logic          err,
   input logic [2:0]    busy,
   input logic          irq
);
   logic glb_wr;
   assign glb_wr = bus_wr && (bus_addr == 2'd0);

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(glb_wr && bus_wdata[3])) |=> err); // R8

   AST_CNT_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[0]) |-> $past(bus_wr && bus_addr == 2'd1)); // R3

   AST_SYNC_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!xsel && $past(!xsel)) |-> (busy == 3'b000)); // R5

   AST_IRQ_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(glb_wr && bus_wdata[4])); // R9

   AST_PRST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (prst && !xsel && !shold && !(glb_wr && bus_wdata[1])) |=> !prst); // R10

   AST_PRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (prst && shold) |=> prst); // R11

   AST_SWITCH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(xsel) |-> (busy == 3'b000)); // R12
endmodule

bind async_timer_bridge atb_checker #(.DW(CNT_W)) u_chk (
   .clk       (clk_sys),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .xsel      (xsel_q),
   .prst      (prst_q),
   .shold     (shold_q),
   .err       (err_q),
   .busy      (busy),
   .irq       (irq)
);

// File: tb/async_timer_bridge_tb.sv
`timescale 1ns/1ps
module async_timer_bridge_tb;
   logic       clk_sys = 1'b0;
   logic       clk_xtal = 1'b0;
   logic       xtal_en = 1'b1;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq;
   int         n_chk = 0;
   int         n_err = 0;
   bit         done = 1'b0;

   async_timer_bridge u_dut (
      .clk_sys   (clk_sys),
      .rst_n     (rst_n),
      .clk_xtal  (clk_xtal),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   always #2.5 clk_sys = ~clk_sys;

   initial begin
      forever begin
         #18.5;
         if (xtal_en) clk_xtal = ~clk_xtal;
      end
   end

   // expected global-register image from its fields
   function automatic logic [7:0] glb_img(bit xs, bit pr, bit sh, bit er, bit mf, logic [2:0] bz);
      return {bz, mf, er, sh, pr, xs};
   endfunction

   function automatic logic [7:0] busy_of(logic [7:0] g);
      return {5'd0, g[7:5]};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk_sys);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk_sys);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk_sys);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] g;
      for (int i = 0; i < 500; i++) begin
         rd(2'd0, g);
         if (g[7:5] == 3'b000) return;
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk_sys);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v, a, b, c;
      logic [7:0] exp_cmp, exp_ctl;
      int seed;
      seed = $urandom(32'h1F2E3D4C);

      repeat (6) @(negedge clk_sys);
      rst_n = 1'b1;

      // R1 reset state
      for (int r = 0; r < 4; r++) begin
         rd(2'(r), v);
         chk("R1 reset read", v, 0);
      end
      chk("R1 irq at reset", irq, 0);

      // R5 system-clock mode: direct update, no busy
      wr(2'd1, 8'h5A);
      rd(2'd0, v);
      chk("R5 no busy in sync mode", v, glb_img(0, 0, 0, 0, 0, 3'b000));
      rd(2'd1, v);
      chk("R5 count written directly", v, 8'h5A);

      // R6 holding read-back, random values, timer stopped
      for (int k = 0; k < 5; k++) begin
         exp_cmp = 8'($urandom);
         exp_ctl = 8'($urandom) & 8'hF8;
         wr(2'd2, exp_cmp);
         wr(2'd3, exp_ctl);
         rd(2'd2, v);
         chk("R6 compare readback sync", v, exp_cmp);
         rd(2'd3, v);
         chk("R6 control readback sync", v, exp_ctl);
      end

      // R2 / R13: sync mode counts from clk_sys even with crystal stopped
      xtal_en = 1'b0;
      wr(2'd1, 8'h00);
      wr(2'd3, 8'h04);
      repeat (80) @(negedge clk_sys);
      rd(2'd1, v);
      chk_rng("R13 divide-by-8 rate", v, 9, 11);
      chk_rng("R2 system clock drives timer", v, 1, 255);
      wr(2'd3, 8'h00);
      wr(2'd1, 8'h00);
      wr(2'd3, 8'h01);
      repeat (20) @(negedge clk_sys);
      rd(2'd1, v);
      chk_rng("R13 divide-by-1 rate", v, 19, 23);
      wr(2'd3, 8'h00);
      rd(2'd1, a);
      repeat (20) @(negedge clk_sys);
      rd(2'd1, b);
      chk("R13 select 0 stops count", b, a);
      xtal_en = 1'b1;

      // R10 sync-mode prescaler reset clears at once
      wr(2'd0, 8'h02);
      rd(2'd0, v);
      chk("R10 sync prescaler reset self-clears", v[1], 0);

      // R9 compare match in sync mode
      wr(2'd2, 8'h40);
      wr(2'd1, 8'h3B);
      wr(2'd3, 8'h01);
      rd(2'd0, v);
      chk("R9 no match before compare", v[4], 0);
      repeat (20) @(negedge clk_sys);
      rd(2'd0, v);
      chk("R9 match flag set", v[4], 1);
      chk("R9 irq set", irq, 1);
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h10);
      rd(2'd0, v);
      chk("R9 write-1 clears flag", v[4], 0);
      chk("R9 irq cleared", irq, 0);

      // R11 hold keeps prescaler reset and freezes count
      wr(2'd1, 8'h00);
      wr(2'd3, 8'h01);
      wr(2'd0, 8'h06);
      rd(2'd1, a);
      repeat (30) @(negedge clk_sys);
      rd(2'd1, b);
      chk("R11 count frozen while held", b, a);
      rd(2'd0, v);
      chk("R11 reset bit persists", v[1], 1);
      wr(2'd0, 8'h00);
      repeat (10) @(negedge clk_sys);
      rd(2'd0, v);
      chk("R11 reset bit released", v[1], 0);
      rd(2'd1, c);
      chk("R11 count resumes", (c != b), 1);
      wr(2'd3, 8'h00);
      wr(2'd2, 8'hC3);

      // R12 switching to crystal flushes holding copies
      wr(2'd0, 8'h01);
      rd(2'd2, v);
      chk("R12 compare holding cleared", v, 0);
      rd(2'd3, v);
      chk("R12 control holding cleared", v, 0);

      // R3 / R4 / R7 crystal-mode count transfer
      wr(2'd1, 8'hA7);
      rd(2'd0, v);
      chk("R4 only count busy", busy_of(v), 8'h01);
      @(posedge clk_xtal);
      @(posedge clk_xtal);
      bus_addr = 2'd0;
      #0.5;
      chk("R3 busy after two crystal edges", bus_rdata[5], 1);
      wait_idle();
      rd(2'd0, v);
      chk("R3 busy cleared", v[5], 0);
      repeat (4) @(negedge clk_sys);
      rd(2'd1, v);
      chk("R7 transferred count", v, 8'hA7);

      // R8 write while busy is dropped
      wr(2'd1, 8'h11);
      wr(2'd1, 8'h22);
      rd(2'd0, v);
      chk("R8 sticky error set", v[3], 1);
      wait_idle();
      repeat (4) @(negedge clk_sys);
      rd(2'd1, v);
      chk("R8 second write dropped", v, 8'h11);
      wr(2'd0, 8'h09);
      rd(2'd0, v);
      chk("R8 error cleared by write 1", v[3], 0);

      // R6 / R4 crystal mode: holding visible while busy
      for (int k = 0; k < 4; k++) begin
         exp_cmp = 8'($urandom);
         wr(2'd2, exp_cmp);
         rd(2'd2, v);
         chk("R6 compare holding while busy", v, exp_cmp);
         rd(2'd0, v);
         chk("R4 only compare busy", busy_of(v), 8'h02);
         wait_idle();
         exp_ctl = 8'($urandom) & 8'hF8;
         wr(2'd3, exp_ctl);
         rd(2'd0, v);
         chk("R4 only control busy", busy_of(v), 8'h04);
         wait_idle();
         rd(2'd3, v);
         chk("R6 control holding", v, exp_ctl);
      end

      // R2 crystal drives the timer
      wr(2'd1, 8'h00);
      wait_idle();
      wr(2'd3, 8'h01);
      wait_idle();
      repeat (20) @(negedge clk_sys);
      xtal_en = 1'b0;
      repeat (10) @(negedge clk_sys);
      rd(2'd1, b);
      repeat (50) @(negedge clk_sys);
      rd(2'd1, c);
      chk("R2 crystal stopped freezes count", c, b);
      xtal_en = 1'b1;
      repeat (50) @(negedge clk_sys);
      rd(2'd1, v);
      chk("R2 crystal restart advances count", (v != c), 1);

      // R10 crystal-mode prescaler reset waits for acknowledge
      wr(2'd0, 8'h03);
      rd(2'd0, v);
      chk("R10 async reset bit still set", v[1], 1);
      repeat (200) @(negedge clk_sys);
      rd(2'd0, v);
      chk("R10 async reset bit cleared", v[1], 0);

      // R9 crystal-mode match
      wr(2'd2, 8'h30);
      wait_idle();
      wr(2'd1, 8'h20);
      wait_idle();
      wr(2'd0, 8'h11);
      rd(2'd0, v);
      chk("R9 flag clear before match", v[4], 0);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk_sys);
         if (irq) break;
      end
      chk("R9 crystal-mode irq", irq, 1);
      wr(2'd3, 8'h00);
      wait_idle();
      repeat (10) @(negedge clk_sys);
      wr(2'd0, 8'h11);
      rd(2'd0, v);
      chk("R9 crystal-mode flag cleared", v[4], 0);

      // R12 switch away in the middle of a transfer
      wr(2'd2, 8'h77);
      wr(2'd0, 8'h00);
      rd(2'd0, v);
      chk("R12 busy flushed on switch", v, glb_img(0, 0, 0, 0, 0, 3'b000));
      rd(2'd2, v);
      chk("R12 compare holding flushed", v, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule